// File: doc/BRIEF.md
# I2C Master Host Register and Interrupt Block

This block is the processor-facing half of an I2C bus master. A 32-bit register bus, addressed in bytes with one register per word, reaches a command queue that feeds the byte engine and a receive queue that the byte engine fills. It also reaches the control fields, three bus timing counts, and an interrupt unit. Each queue has a level that software can read. A command entry is ten bits wide: a start request, a stop request and a data or address byte. The byte engine pops commands when it is ready for them and pushes received bytes. It also reports a busy level and single-cycle pulses when a NACK is seen or arbitration is lost.

Five status sources drive the interrupt. Two of them are live levels computed from the queue levels against programmable thresholds. The other three are error flags that hold until software writes one to them. A separate enable mask selects which sources raise the single registered interrupt line. When the core enable bit is cleared, both queues are emptied and the error flags are dropped. Toggling that bit therefore returns the block to a clean state before the next message.

Top module: `i2c_host_regs`

## Requirements
- R1: Reset leaves control, enable mask, timing counts and both queue levels at zero and the interrupt low. The status register then reads 0x01 (TX ready only), and the command-valid output is low.
- R2: Word offsets decode as follows. 0x08 is control: bit0 enable, bit1 fast speed, bits3:2 command threshold, bits5:4 receive threshold. 0x0C is the 5-bit enable mask. 0x20, 0x24 and 0x28 are the 16-bit SCL-low, SCL-high and SDA-hold counts, which also drive their output ports. Read data appears the cycle after the read strobe. Unmapped offsets and offset 0x00 read as zero.
- R3: A write to 0x00 while enabled queues bits 9:0 (bit9 start, bit8 stop, bits7:0 byte). The engine sees the entries in write order on its command port. Offset 0x18 reads the number of queued entries.
- R4: A command write while the queue holds FIFO_DEPTH (4) entries is dropped, and the level stays at 4.
- R5: A read of 0x04 returns the oldest received byte in bits 7:0 and removes it. Offset 0x1C reads the number of stored bytes. A read of 0x04 on an empty queue returns 0 and leaves the level at 0.
- R6: An engine push into a full receive queue drops the byte and sets status bit4 (RX overflow).
- R7: The status bits at 0x10 are: bit0 TX ready, bit1 RX ready, bit2 NACK, bit3 arbitration lost, bit4 RX overflow. The engine pulses set bits 2 and 3. Writing 1 to bits 4:2 clears them, and writing 0 leaves them set. A set and a clear in the same cycle leave the bit set.
- R8: TX ready is 1 while the command level is at most the command threshold. RX ready is 1 while the receive level exceeds the receive threshold. Writes to bits 1:0 have no effect on them.
- R9: The interrupt output is 1 exactly one cycle after any status bit and its enable bit are both 1.
- R10: While enable is 0, both queues are emptied and bits 4:2 are cleared. Command writes, engine pushes and engine pulses are ignored. After re-enabling, both queues start empty.
- R11: Offset 0x14 bit0 reads the engine busy input.
- R12: An engine pop on an empty command queue is ignored, and command-valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address of the register access |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRead |
| engCmdPop | input | 1 | Engine takes the head command |
| engCmdValid | output | 1 | Command queue not empty |
| engCmdData | output | 10 | Head command: start, stop, byte |
| engRxPush | input | 1 | Engine delivers a received byte |
| engRxData | input | 8 | Received byte |
| engBusy | input | 1 | Engine busy level |
| engNackPulse | input | 1 | NACK seen, one-cycle pulse |
| engArbPulse | input | 1 | Arbitration lost, one-cycle pulse |
| cfgEnable | output | 1 | Core enable |
| cfgFast | output | 1 | Fast bus speed selected |
| cfgSclLow | output | 16 | SCL low count |
| cfgSclHigh | output | 16 | SCL high count |
| cfgSdaHold | output | 16 | SDA hold count |
| irqOut | output | 1 | Registered interrupt |

## Verification
The queues are tested with directed fill and drain sequences that distinguish three cases: correct ordering, dropping of the extra entry at depth four, and an empty read or pop that leaves the level alone. A seeded random mix of command writes, engine pops, engine pushes, data reads and status reads is then compared against a queue model. This covers interleavings the directed cases miss, such as a pop following an overflow. Thresholds set to one separate the "at most" comparison for TX ready from the "greater than" comparison for RX ready. A same-cycle write-one-clear and NACK pulse shows which of the two wins.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam int CMD_W  = 10;
  localparam int STAT_W = 5;
  localparam int CTRL_W = 6;

  // word indices on the register bus
  localparam int IDX_CMD    = 0;
  localparam int IDX_RXDATA = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_IEN    = 3;
  localparam int IDX_IST    = 4;
  localparam int IDX_STAT   = 5;
  localparam int IDX_CMDLVL = 6;
  localparam int IDX_RXLVL  = 7;
  localparam int IDX_LOW    = 8;
  localparam int IDX_HIGH   = 9;
  localparam int IDX_HOLD   = 10;

  // status bit positions
  localparam int ST_TX   = 0;
  localparam int ST_RX   = 1;
  localparam int ST_NACK = 2;
  localparam int ST_ARB  = 3;
  localparam int ST_OVF  = 4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RXDATA, SEL_CTRL, SEL_IEN, SEL_IST, SEL_STAT,
    SEL_CMDLVL, SEL_RXLVL, SEL_LOW, SEL_HIGH, SEL_HOLD
  } rdSel_e;

  typedef struct packed {
    logic   cmdPush;
    logic   rxPop;
    logic   ctrlWr;
    logic   ienWr;
    logic   istClr;
    logic   lowWr;
    logic   highWr;
    logic   holdWr;
    logic   rdEn;
    rdSel_e rdSel;
  } hostStrobe_t;
endpackage

// File: rtl/i2c_host_fifo.sv
module i2c_host_fifo #(
  parameter  int WIDTH = 8,
  parameter  int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (level == LVL_W'(DEPTH));
  assign empty  = (level == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + LVL_W'(1);
      else if (doPop && !doPush) level <= level - LVL_W'(1);
    end
  end
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2c_host_pkg::*;
#(
  parameter  int ADDR_W = 6,
  localparam int IDX_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output hostStrobe_t       strb
);
  logic [IDX_W-1:0] wordIdx;
  logic [1:0] unusedByteLane;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedByteLane = busAddr[1:0];

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    strb.rdEn  = busRead;
    if (busWrite) begin
      case (int'(wordIdx))
        IDX_CMD:  strb.cmdPush = 1'b1;
        IDX_CTRL: strb.ctrlWr  = 1'b1;
        IDX_IEN:  strb.ienWr   = 1'b1;
        IDX_IST:  strb.istClr  = 1'b1;
        IDX_LOW:  strb.lowWr   = 1'b1;
        IDX_HIGH: strb.highWr  = 1'b1;
        IDX_HOLD: strb.holdWr  = 1'b1;
        default: ;
      endcase
    end
    if (busRead) begin
      case (int'(wordIdx))
        IDX_RXDATA: begin
          strb.rdSel = SEL_RXDATA;
          strb.rxPop = 1'b1;
        end
        IDX_CTRL:   strb.rdSel = SEL_CTRL;
        IDX_IEN:    strb.rdSel = SEL_IEN;
        IDX_IST:    strb.rdSel = SEL_IST;
        IDX_STAT:   strb.rdSel = SEL_STAT;
        IDX_CMDLVL: strb.rdSel = SEL_CMDLVL;
        IDX_RXLVL:  strb.rdSel = SEL_RXLVL;
        IDX_LOW:    strb.rdSel = SEL_LOW;
        IDX_HIGH:   strb.rdSel = SEL_HIGH;
        IDX_HOLD:   strb.rdSel = SEL_HOLD;
        default:    strb.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_host_dpath.sv
module i2c_host_dpath
  import i2c_host_pkg::*;
#(
  parameter  int FIFO_DEPTH = 4,
  parameter  int CNT_W      = 16,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              engCmdPop,
  output logic              engCmdValid,
  output logic [CMD_W-1:0]  engCmdData,
  input  logic              engRxPush,
  input  logic [7:0]        engRxData,
  input  logic              engBusy,
  input  logic              engNackPulse,
  input  logic              engArbPulse,
  output logic              cfgEnable,
  output logic              cfgFast,
  output logic [CNT_W-1:0]  cfgSclLow,
  output logic [CNT_W-1:0]  cfgSclHigh,
  output logic [CNT_W-1:0]  cfgSdaHold,
  output logic              irqOut,
  output logic [LVL_W-1:0]  cmdLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic [STAT_W-1:0] statusVec,
  output logic [STAT_W-1:0] ienVec
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [STAT_W-1:0] ienReg;
  logic [CNT_W-1:0]  lowReg, highReg, holdReg;
  logic nackFlag, arbFlag, ovfFlag;
  logic [1:0] cmdThr, rxThr;
  logic [CMD_W-1:0] cmdHead;
  logic [7:0] rxHead;
  logic cmdFull, cmdEmpty, rxFull, rxEmpty;
  logic txRdy, rxRdy, ovfEvt;
  logic [STAT_W-1:0] clrMask;
  logic [31:0] rdNext;
  logic unusedWdata;

  assign unusedWdata = ^busWdata;
  assign cfgEnable   = ctrlReg[0];
  assign cfgFast     = ctrlReg[1];
  assign cmdThr      = ctrlReg[3:2];
  assign rxThr       = ctrlReg[5:4];
  assign cfgSclLow   = lowReg;
  assign cfgSclHigh  = highReg;
  assign cfgSdaHold  = holdReg;

  // both queues live only while the core is enabled
  i2c_host_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) cmdFifo (
    .clk(clk), .rstN(rstN), .flush(!cfgEnable),
    .push(strb.cmdPush && cfgEnable), .pop(engCmdPop && cfgEnable),
    .wrData(busWdata[CMD_W-1:0]), .headData(cmdHead),
    .level(cmdLevel), .full(cmdFull), .empty(cmdEmpty)
  );

  i2c_host_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(!cfgEnable),
    .push(engRxPush && cfgEnable), .pop(strb.rxPop),
    .wrData(engRxData), .headData(rxHead),
    .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );

  assign engCmdValid = !cmdEmpty;
  assign engCmdData  = cmdEmpty ? '0 : cmdHead;

  // live ready conditions against thresholds
  assign txRdy  = 32'(cmdLevel) <= 32'(cmdThr);
  assign rxRdy  = 32'(rxLevel) > 32'(rxThr);
  assign ovfEvt = engRxPush && cfgEnable && rxFull;

  assign statusVec = {ovfFlag, arbFlag, nackFlag, rxRdy, txRdy};
  assign ienVec    = ienReg;
  assign clrMask   = strb.istClr ? busWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ienReg  <= '0;
      lowReg  <= '0;
      highReg <= '0;
      holdReg <= '0;
    end else begin
      if (strb.ctrlWr) ctrlReg <= busWdata[CTRL_W-1:0];
      if (strb.ienWr)  ienReg  <= busWdata[STAT_W-1:0];
      if (strb.lowWr)  lowReg  <= busWdata[CNT_W-1:0];
      if (strb.highWr) highReg <= busWdata[CNT_W-1:0];
      if (strb.holdWr) holdReg <= busWdata[CNT_W-1:0];
    end
  end

  // latched error flags: set beats clear, disable wipes them
  always_ff @(posedge clk) begin
    if (!rstN || !cfgEnable) begin
      nackFlag <= 1'b0;
      arbFlag  <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      nackFlag <= engNackPulse || (nackFlag && !clrMask[ST_NACK]);
      arbFlag  <= engArbPulse  || (arbFlag  && !clrMask[ST_ARB]);
      ovfFlag  <= ovfEvt       || (ovfFlag  && !clrMask[ST_OVF]);
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_RXDATA: rdNext = rxEmpty ? 32'd0 : 32'(rxHead);
      SEL_CTRL:   rdNext = 32'(ctrlReg);
      SEL_IEN:    rdNext = 32'(ienReg);
      SEL_IST:    rdNext = 32'(statusVec);
      SEL_STAT:   rdNext = 32'(engBusy);
      SEL_CMDLVL: rdNext = 32'(cmdLevel);
      SEL_RXLVL:  rdNext = 32'(rxLevel);
      SEL_LOW:    rdNext = 32'(lowReg);
      SEL_HIGH:   rdNext = 32'(highReg);
      SEL_HOLD:   rdNext = 32'(holdReg);
      default:    rdNext = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      irqOut   <= 1'b0;
    end else begin
      if (strb.rdEn) busRdata <= rdNext;
      irqOut <= |(statusVec & ienReg);
    end
  end
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_host_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              engCmdPop,
  output logic              engCmdValid,
  output logic [CMD_W-1:0]  engCmdData,
  input  logic              engRxPush,
  input  logic [7:0]        engRxData,
  input  logic              engBusy,
  input  logic              engNackPulse,
  input  logic              engArbPulse,
  output logic              cfgEnable,
  output logic              cfgFast,
  output logic [CNT_W-1:0]  cfgSclLow,
  output logic [CNT_W-1:0]  cfgSclHigh,
  output logic [CNT_W-1:0]  cfgSdaHold,
  output logic              irqOut
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  hostStrobe_t       strb;
  logic [LVL_W-1:0]  cmdLevel, rxLevel;
  logic [STAT_W-1:0] statusVec, ienVec;

  i2c_host_ctrl #(.ADDR_W(ADDR_W)) ctrlInst (
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead), .strb(strb)
  );

  i2c_host_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dpathInst (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .engCmdPop(engCmdPop), .engCmdValid(engCmdValid),
    .engCmdData(engCmdData), .engRxPush(engRxPush), .engRxData(engRxData),
    .engBusy(engBusy), .engNackPulse(engNackPulse), .engArbPulse(engArbPulse),
    .cfgEnable(cfgEnable), .cfgFast(cfgFast), .cfgSclLow(cfgSclLow),
    .cfgSclHigh(cfgSclHigh), .cfgSdaHold(cfgSdaHold), .irqOut(irqOut),
    .cmdLevel(cmdLevel), .rxLevel(rxLevel), .statusVec(statusVec),
    .ienVec(ienVec)
  );
endmodule

// File: rtl/i2c_host_regs_chk.sv
module i2c_host_regs_chk
  import i2c_host_pkg::*;
#(
  parameter  int FIFO_DEPTH = 4,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic              engCmdPop,
  input logic              engRxPush,
  input logic              engNackPulse,
  input logic              engArbPulse,
  input logic [LVL_W-1:0]  cmdLevel,
  input logic [LVL_W-1:0]  rxLevel,
  input logic [STAT_W-1:0] statusVec,
  input logic [STAT_W-1:0] ienVec,
  input logic              irqOut
);
  // R10
  flush_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (cmdLevel == '0 && rxLevel == '0 && statusVec[4:2] == '0));

  // R4
  cmd_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && cmdLevel == LVL_W'(FIFO_DEPTH) && !engCmdPop)
      |=> cmdLevel == LVL_W'(FIFO_DEPTH));

  // R3
  cmd_level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLevel <= LVL_W'(FIFO_DEPTH));

  // R6
  rx_overflow_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && engRxPush && rxLevel == LVL_W'(FIFO_DEPTH)) |=> statusVec[ST_OVF]);

  // R7
  nack_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && engNackPulse) |=> statusVec[ST_NACK]);

  // R7
  arb_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && engArbPulse) |=> statusVec[ST_ARB]);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusVec & ienVec)) |=> irqOut);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusVec & ienVec)) |=> !irqOut);
endmodule

bind i2c_host_regs i2c_host_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chkInst (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .engCmdPop(engCmdPop),
  .engRxPush(engRxPush), .engNackPulse(engNackPulse), .engArbPulse(engArbPulse),
  .cmdLevel(cmdLevel), .rxLevel(rxLevel), .statusVec(statusVec),
  .ienVec(ienVec), .irqOut(irqOut)
);

// File: tb/i2c_host_regs_test.sv
module i2c_host_regs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engCmdPop = 1'b0, engCmdValid;
  logic [9:0]  engCmdData;
  logic        engRxPush = 1'b0;
  logic [7:0]  engRxData = '0;
  logic        engBusy = 1'b0, engNackPulse = 1'b0, engArbPulse = 1'b0;
  logic        cfgEnable, cfgFast, irqOut;
  logic [15:0] cfgSclLow, cfgSclHigh, cfgSdaHold;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;
  logic [31:0] rd;

  localparam logic [5:0] A_CMD = 6'h00, A_RXD = 6'h04, A_CTRL = 6'h08,
    A_IEN = 6'h0C, A_IST = 6'h10, A_STAT = 6'h14, A_CLVL = 6'h18,
    A_RLVL = 6'h1C, A_LOW = 6'h20, A_HIGH = 6'h24, A_HOLD = 6'h28;

  always #10 clk = ~clk;

  i2c_host_regs uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk); busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRead = 1'b1;
    @(negedge clk); busRead = 1'b0; d = busRdata;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    chk(req, v, exp);
  endtask

  task automatic engPop();
    @(negedge clk); engCmdPop = 1'b1;
    @(negedge clk); engCmdPop = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk); engRxPush = 1'b1; engRxData = b;
    @(negedge clk); engRxPush = 1'b0;
  endtask

  task automatic pulseNack();
    @(negedge clk); engNackPulse = 1'b1;
    @(negedge clk); engNackPulse = 1'b0;
  endtask

  task automatic pulseArb();
    @(negedge clk); engArbPulse = 1'b1;
    @(negedge clk); engArbPulse = 1'b0;
  endtask

  function automatic logic [31:0] expStat(int cl, int rl, int ct, int rt,
                                          bit nk, bit ab, bit ov);
    return {27'd0, ov, ab, nk, 1'(rl > rt), 1'(cl <= ct)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    finishRun();
  end

  initial begin
    logic [9:0] cmdQ[$];
    logic [7:0] rxQ[$];
    bit ovfM;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irqOut), 0);
    chk("R1 valid", 32'(engCmdValid), 0);
    rdChk("R1 ctrl", A_CTRL, 0);
    rdChk("R1 ien", A_IEN, 0);
    rdChk("R1 status", A_IST, 32'h01);
    rdChk("R1 cmd level", A_CLVL, 0);
    rdChk("R1 rx level", A_RLVL, 0);
    rdChk("R1 low", A_LOW, 0);

    // R2 field decode and readback
    busWr(A_CTRL, 32'hFFFF_FFC3);
    rdChk("R2 ctrl mask", A_CTRL, 32'h03);
    chk("R2 enable pin", 32'(cfgEnable), 1);
    chk("R2 fast pin", 32'(cfgFast), 1);
    busWr(A_LOW, 32'h0001_2345);
    busWr(A_HIGH, 32'h0000_00A7);
    busWr(A_HOLD, 32'h0000_000F);
    rdChk("R2 low", A_LOW, 32'h2345);
    rdChk("R2 high", A_HIGH, 32'hA7);
    rdChk("R2 hold", A_HOLD, 32'h0F);
    chk("R2 low pin", 32'(cfgSclLow), 32'h2345);
    chk("R2 hold pin", 32'(cfgSdaHold), 32'h0F);
    rdChk("R2 unmapped", 6'h2C, 0);
    rdChk("R2 cmd offset reads zero", A_CMD, 0);
    busWr(A_CTRL, 32'h01);

    // R11 busy readout
    engBusy = 1'b1;
    rdChk("R11 busy high", A_STAT, 1);
    engBusy = 1'b0;
    rdChk("R11 busy low", A_STAT, 0);

    // R3 ordering, R12 empty pop
    busWr(A_CMD, 32'h2A5);
    busWr(A_CMD, 32'h13C);
    rdChk("R3 level two", A_CLVL, 2);
    chk("R3 head first", 32'(engCmdData), 32'h2A5);
    engPop();
    chk("R3 head second", 32'(engCmdData), 32'h13C);
    engPop();
    chk("R12 valid low", 32'(engCmdValid), 0);
    engPop();
    rdChk("R12 level after empty pop", A_CLVL, 0);

    // R4 full drop
    for (int i = 1; i <= 5; i++) busWr(A_CMD, 32'h100 + i);
    rdChk("R4 level capped", A_CLVL, 4);
    for (int i = 1; i <= 4; i++) begin
      chk("R4 drain order", 32'(engCmdData), 32'h100 + i);
      engPop();
    end
    chk("R4 empty after drain", 32'(engCmdValid), 0);

    // R5 / R6 receive path and overflow
    engPush(8'h11); engPush(8'h22); engPush(8'h33); engPush(8'h44); engPush(8'h55);
    rdChk("R6 overflow status", A_IST, 32'h13);
    rdChk("R5 rx level", A_RLVL, 4);
    rdChk("R5 byte 1", A_RXD, 32'h11);
    rdChk("R5 byte 2", A_RXD, 32'h22);
    rdChk("R5 byte 3", A_RXD, 32'h33);
    rdChk("R6 dropped byte absent", A_RXD, 32'h44);
    rdChk("R5 empty read", A_RXD, 0);
    rdChk("R5 level stays zero", A_RLVL, 0);
    busWr(A_IST, 32'h10);
    rdChk("R7 overflow cleared", A_IST, 32'h01);

    // R7 latch, clear, set-beats-clear
    pulseNack();
    pulseArb();
    rdChk("R7 nack and arb", A_IST, 32'h0D);
    busWr(A_IST, 32'h0);
    rdChk("R7 write zero keeps", A_IST, 32'h0D);
    busWr(A_IST, 32'h08);
    rdChk("R7 clear arb only", A_IST, 32'h05);
    @(negedge clk);
    busAddr = A_IST; busWdata = 32'h04; busWrite = 1'b1; engNackPulse = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; engNackPulse = 1'b0;
    rdChk("R7 set beats clear", A_IST, 32'h05);
    busWr(A_IST, 32'h1F);
    rdChk("R8 ready bits ignore write", A_IST, 32'h01);

    // R8 thresholds at one
    busWr(A_CTRL, 32'h15);
    busWr(A_CMD, 32'h001);
    rdChk("R8 tx ready at threshold", A_IST, 32'h01);
    busWr(A_CMD, 32'h002);
    rdChk("R8 tx not ready above", A_IST, 32'h00);
    engPush(8'hA1);
    rdChk("R8 rx not ready at threshold", A_IST, 32'h00);
    engPush(8'hA2);
    rdChk("R8 rx ready above", A_IST, 32'h02);
    busWr(A_CTRL, 32'h00);
    busWr(A_CTRL, 32'h01);

    // R9 interrupt
    busWr(A_IEN, 32'h04);
    @(negedge clk);
    chk("R9 masked tx ready no irq", 32'(irqOut), 0);
    pulseNack();
    @(negedge clk);
    chk("R9 nack irq", 32'(irqOut), 1);
    busWr(A_IST, 32'h04);
    @(negedge clk);
    chk("R9 irq drops", 32'(irqOut), 0);
    busWr(A_IEN, 32'h01);
    @(negedge clk);
    chk("R9 tx ready irq", 32'(irqOut), 1);
    busWr(A_CMD, 32'h0AA);
    @(negedge clk);
    chk("R9 irq follows tx ready", 32'(irqOut), 0);
    busWr(A_IEN, 32'h00);

    // R10 disable flush
    engPush(8'h77);
    pulseArb();
    busWr(A_CTRL, 32'h00);
    rdChk("R10 cmd flushed", A_CLVL, 0);
    rdChk("R10 rx flushed", A_RLVL, 0);
    rdChk("R10 flags cleared", A_IST, 32'h01);
    busWr(A_CMD, 32'h155);
    engPush(8'h66);
    pulseNack();
    rdChk("R10 cmd write ignored", A_CLVL, 0);
    rdChk("R10 push ignored", A_RLVL, 0);
    rdChk("R10 pulse ignored", A_IST, 32'h01);
    busWr(A_CTRL, 32'h01);
    rdChk("R10 reenable empty", A_CLVL, 0);
    chk("R10 reenable no valid", 32'(engCmdValid), 0);

    // random mix against a queue model (thresholds zero)
    ovfM = 1'b0;
    for (int n = 0; n < 300; n++) begin
      case ($urandom_range(4, 0))
        0: begin
          logic [9:0] c;
          c = 10'($urandom());
          busWr(A_CMD, 32'(c));
          if (cmdQ.size() < 4) cmdQ.push_back(c);
        end
        1: begin
          chk("R3 random valid", 32'(engCmdValid), 32'(cmdQ.size() > 0));
          if (cmdQ.size() > 0) begin
            chk("R3 random head", 32'(engCmdData), 32'(cmdQ[0]));
            void'(cmdQ.pop_front());
          end
          engPop();
        end
        2: begin
          logic [7:0] b;
          b = 8'($urandom());
          engPush(b);
          if (rxQ.size() == 4) ovfM = 1'b1;
          else rxQ.push_back(b);
        end
        3: begin
          busRd(A_RXD, rd);
          if (rxQ.size() > 0) begin
            chk("R5 random data", rd, 32'(rxQ[0]));
            void'(rxQ.pop_front());
          end else chk("R5 random empty read", rd, 0);
        end
        default: begin
          rdChk("R6 random status", A_IST,
                expStat(cmdQ.size(), rxQ.size(), 0, 0, 1'b0, 1'b0, ovfM));
          busWr(A_IST, 32'h10);
          ovfM = 1'b0;
        end
      endcase
      rdChk("R3 random cmd level", A_CLVL, 32'(cmdQ.size()));
      rdChk("R5 random rx level", A_RLVL, 32'(rxQ.size()));
    end

    finishRun();
  end
endmodule